// File: doc/BRIEF.md
# Serial Receive Queue with Status Flags

This block is the receive buffer of a serial port. A line receiver offers it one character per cycle, along with three error bits and a separate break strobe. The block stores each accepted character as a 12-bit entry in a circular store. The low 8 bits hold the data and the high 4 bits hold the error field. A host read of the data port removes the oldest entry and latches that entry's error field into a status register.

A mode input selects the queue depth. In deep mode the queue holds 16 entries. In holding-register mode it holds a single entry. Any change of the mode input empties the queue.

The block drives four status signals from its own state:
- a can-accept output for the line receiver,
- empty and full flags,
- a raw receive-interrupt bit that follows a trigger level.

A character that arrives while the queue cannot take it is dropped. That loss is recorded as an overrun bit on the next entry that is stored.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, rxEmpty=1, rxFull=0, rxIntRaw=0, errStatus=0 and canAccept=1.
- R2: canAccept is high exactly when the stored count is below 16 with fifoEnable=1, or when the count is 0 with fifoEnable=0.
- R3: Entries leave in arrival order, and the pointers wrap through all 16 slots. popData shows the oldest entry as {err[3:0], data[7:0]}, where err bit 0 (entry bit 8) is framing, bit 1 (entry bit 9) is parity, bit 2 (entry bit 10) is break and bit 3 (entry bit 11) is overrun. pushErr[2:0] fills entry bits 10:8.
- R4: rxEmpty is high exactly when the stored count is 0.
- R5: rxFull is set by an accepted push when fifoEnable=0, or when that push brings the count to 16. It is cleared by any pop, including a pop of an empty queue. rxEmpty and rxFull are never both high.
- R6: On every pop, errStatus takes bits 11:8 of the entry shown on popData in that cycle. It holds its value at all other times.
- R7: rxIntRaw is set when a push brings the count to the trigger level (1). It is cleared when a pop leaves the count at trigger level minus one (0), and this includes a pop of an empty queue. A flush leaves it unchanged.
- R8: A breakEvent pushes the entry 0x400 (break bit set, data zero). If pushValid is also high in that cycle, the break wins and the character is discarded.
- R9: A push offered while canAccept is low is dropped. It arms an overrun mark, and the next accepted entry is stored with bit 11 set. The mark then clears.
- R10: When a push and a pop fall in the same cycle on a non-empty queue, the pop returns the old head and the count stays the same.
- R11: A change of fifoEnable from its previous-cycle value empties the queue: the count and read pointer return to zero and rxFull clears. A push or pop offered in that cycle is discarded. The registered reference value resets to 0.
- R12: A pop of an empty queue leaves the count and read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEnable | input | 1 | 1 = 16-deep mode, 0 = single holding register |
| pushValid | input | 1 | Line receiver offers a character this cycle |
| pushData | input | 8 | Received character |
| pushErr | input | 3 | Framing, parity and break bits for the character |
| breakEvent | input | 1 | Break detected; stores entry 0x400 |
| canAccept | output | 1 | Queue can take a push this cycle |
| popReq | input | 1 | Host reads the data port |
| popData | output | 12 | Oldest stored entry {err, data} |
| rxEmpty | output | 1 | Queue is empty |
| rxFull | output | 1 | Queue is full for the current mode |
| rxIntRaw | output | 1 | Raw receive interrupt |
| errStatus | output | 4 | Error field of the last popped entry |

## Verification
The bench first moves the read pointer to each of the 16 start offsets. At each offset it fills the queue to capacity, overflows it once and drains it. This separates correct wrap-around and full detection from errors that only show up at particular slot positions.

Further patterns cover single-register mode, a push and a pop in the same cycle at several fill levels, and a break arriving together with a character. They also cover mode toggles on a non-empty queue and pops of an empty queue. Each pattern isolates a flag rule that the fill-and-drain sweep cannot reach: the precedence between push and pop, break priority, flush clearing and the interrupt staying set across a flush.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic push;      // accepted write into the store
    logic pop;       // host read request (raw)
    logic flush;     // mode change this cycle
    logic markOvr;   // stamp overrun bit on the written entry
    logic useBreak;  // written entry is the break code
  } rxqStrobe_t;

  localparam int RXQ_ERR_W = 4;

endpackage

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEnable,
  input  logic          pushValid,
  input  logic          breakEvent,
  input  logic          popReq,
  output rxqStrobe_t    strb,
  output logic [PW-1:0] wrIdx,
  output logic [PW-1:0] rdIdx,
  output logic          canAccept,
  output logic          rxEmpty,
  output logic          rxFull,
  output logic          rxIntRaw
);

  localparam logic [CW-1:0] DepthC  = CW'(DEPTH);
  localparam logic [CW-1:0] TrigC   = CW'(TRIG);
  localparam logic [CW-1:0] TrigM1C = CW'(TRIG - 1);

  logic [CW-1:0] cnt, cntNext;
  logic [PW-1:0] rdPtr;
  logic          modePrev, fullQ, intQ, ovrPend;
  logic          flush, anyIn, doPush, doPop, popMoves;

  always_comb begin
    flush     = fifoEnable != modePrev;
    canAccept = fifoEnable ? (cnt < DepthC) : (cnt == '0);
    anyIn     = pushValid | breakEvent;
    doPush    = anyIn & canAccept & ~flush;
    doPop     = popReq & ~flush;
    popMoves  = doPop & (cnt != '0);
    cntNext   = cnt + CW'(doPush) - CW'(popMoves);
    wrIdx     = rdPtr + cnt[PW-1:0];
    rdIdx     = rdPtr;
    rxEmpty   = (cnt == '0);
    rxFull    = fullQ;
    rxIntRaw  = intQ;
    strb.push     = doPush;
    strb.pop      = popReq;
    strb.flush    = flush;
    strb.markOvr  = ovrPend;
    strb.useBreak = breakEvent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      rdPtr    <= '0;
      modePrev <= 1'b0;
      fullQ    <= 1'b0;
      intQ     <= 1'b0;
      ovrPend  <= 1'b0;
    end else begin
      modePrev <= fifoEnable;
      if (flush) begin
        cnt   <= '0;
        rdPtr <= '0;
        fullQ <= 1'b0;
      end else begin
        cnt <= cntNext;
        if (popMoves) rdPtr <= rdPtr + 1'b1;
        if (doPush && (!fifoEnable || cntNext == DepthC)) fullQ <= 1'b1;
        else if (doPop)                                  fullQ <= 1'b0;
        if (doPush && cntNext == TrigC)                  intQ <= 1'b1;
        else if (doPop && cntNext == TrigM1C)            intQ <= 1'b0;
        if (doPush)                                      ovrPend <= 1'b0;
        else if (anyIn && !canAccept)                    ovrPend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_rx_fifo_data.sv
module uart_rx_fifo_data
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int EW   = RXQ_ERR_W,
  localparam int ENW  = DW + EW
) (
  input  logic           clk,
  input  logic           rstN,
  input  rxqStrobe_t     strb,
  input  logic [PW-1:0]  wrIdx,
  input  logic [PW-1:0]  rdIdx,
  input  logic [DW-1:0]  pushData,
  input  logic [EW-2:0]  pushErr,
  output logic [ENW-1:0] popData,
  output logic [EW-1:0]  errStatus
);

  logic [ENW-1:0] slot [DEPTH];
  logic [ENW-1:0] inEntry;

  always_comb begin
    if (strb.useBreak) begin
      inEntry = '0;
      inEntry[DW+2] = 1'b1;
    end else begin
      inEntry = {1'b0, pushErr, pushData};
    end
    if (strb.markOvr) inEntry[ENW-1] = 1'b1;
    popData = slot[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (strb.push) begin
      slot[wrIdx] <= inEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        errStatus <= '0;
    else if (strb.pop && !strb.flush) errStatus <= popData[ENW-1:DW];
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int EW   = RXQ_ERR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEnable,
  input  logic             pushValid,
  input  logic [DW-1:0]    pushData,
  input  logic [EW-2:0]    pushErr,
  input  logic             breakEvent,
  output logic             canAccept,
  input  logic             popReq,
  output logic [DW+EW-1:0] popData,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             rxIntRaw,
  output logic [EW-1:0]    errStatus
);

  rxqStrobe_t    strb;
  logic [PW-1:0] wrIdx, rdIdx;

  uart_rx_fifo_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) uCtrl (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .pushValid(pushValid),
    .breakEvent(breakEvent), .popReq(popReq), .strb(strb), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .canAccept(canAccept), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .rxIntRaw(rxIntRaw)
  );

  uart_rx_fifo_data #(.DEPTH(DEPTH), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .pushData(pushData), .pushErr(pushErr), .popData(popData),
    .errStatus(errStatus)
  );

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          fifoEnable,
  input logic          pushValid,
  input logic          breakEvent,
  input logic          popReq,
  input logic          canAccept,
  input logic          rxEmpty,
  input logic          rxFull,
  input logic          rxIntRaw,
  input logic [DW+3:0] popData,
  input logic [3:0]    errStatus,
  input logic          flushS
);

  assert_single_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEnable && !rxEmpty) |-> !canAccept);

  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEnable && rxFull && !flushS) |-> !canAccept);

  assert_empty_full_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEmpty && rxFull));

  assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !flushS && !pushValid && !breakEvent) |=> !rxFull);

  assert_err_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !flushS) |=> errStatus == $past(popData[DW+3:DW]));

  assert_int_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIntRaw) |-> !rxEmpty);

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    flushS |=> rxEmpty);

  assert_pop_empty_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxEmpty && popReq && !pushValid && !breakEvent && !flushS) |=> rxEmpty);

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .pushValid(pushValid),
  .breakEvent(breakEvent), .popReq(popReq), .canAccept(canAccept),
  .rxEmpty(rxEmpty), .rxFull(rxFull), .rxIntRaw(rxIntRaw), .popData(popData),
  .errStatus(errStatus), .flushS(strb.flush)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoEnable = 1'b0;
  logic        pushValid = 1'b0;
  logic [7:0]  pushData = '0;
  logic [2:0]  pushErr = '0;
  logic        breakEvent = 1'b0;
  logic        popReq = 1'b0;
  logic        canAccept, rxEmpty, rxFull, rxIntRaw;
  logic [11:0] popData;
  logic [3:0]  errStatus;

  int total = 0;
  int bad = 0;

  // Reference state derived from the requirements.
  logic [11:0] q[$];
  bit          fifoM = 0, fullM = 0, intM = 0, ovrM = 0, errKnown = 1;
  logic [3:0]  errM = '0;

  always #4 clk = ~clk;

  uart_rx_fifo dut (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .pushValid(pushValid),
    .pushData(pushData), .pushErr(pushErr), .breakEvent(breakEvent),
    .canAccept(canAccept), .popReq(popReq), .popData(popData),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxIntRaw(rxIntRaw),
    .errStatus(errStatus)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkState();
    chk("R4 rxEmpty", 32'(rxEmpty), 32'(q.size() == 0));
    chk("R5 rxFull", 32'(rxFull), 32'(fullM));
    chk("R7 rxIntRaw", 32'(rxIntRaw), 32'(intM));
    if (errKnown) chk("R6 errStatus", 32'(errStatus), 32'(errM));
  endtask

  // One cycle: inputs applied away from the edge, model updated after it.
  task automatic step(bit p, bit b, logic [7:0] d, logic [2:0] e, bit r,
                      string tag = "R3");
    bit          canM;
    logic [11:0] ent;
    canM = fifoM ? (q.size() < 16) : (q.size() == 0);
    ent  = b ? 12'h400 : {1'b0, e, d};
    pushValid = p; breakEvent = b; pushData = d; pushErr = e; popReq = r;
    #1;
    chk("R2 canAccept", 32'(canAccept), 32'(canM));
    if (r && q.size() > 0) chk(tag, 32'(popData), 32'(q[0]));
    @(posedge clk); #1;
    pushValid = 0; breakEvent = 0; popReq = 0;
    if (r) begin
      if (q.size() > 0) begin
        errM = q[0][11:8]; errKnown = 1;
        void'(q.pop_front());
      end else errKnown = 0;
      fullM = 0;
      if (q.size() == 0) intM = 0;
    end
    if ((p || b) && canM) begin
      if (ovrM) ent[11] = 1'b1;
      ovrM = 0;
      q.push_back(ent);
      if (!fifoM || q.size() == 16) fullM = 1;
      if (q.size() == 1) intM = 1;
    end else if (p || b) ovrM = 1;
    checkState();
  endtask

  // Mode change with a push offered in the same cycle (R11: discarded).
  task automatic flip(bit en);
    fifoEnable = en; fifoM = en;
    pushValid = 1; pushData = 8'h99;
    @(posedge clk); #1;
    pushValid = 0;
    q.delete(); fullM = 0;
    chk("R11 empty after flush", 32'(rxEmpty), 32'd1);
    chk("R11 full cleared", 32'(rxFull), 32'd0);
    chk("R11 canAccept", 32'(canAccept), 32'd1);
    chk("R7 int kept over flush", 32'(rxIntRaw), 32'(intM));
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    chk("R1 rxEmpty", 32'(rxEmpty), 32'd1);
    chk("R1 rxFull", 32'(rxFull), 32'd0);
    chk("R1 rxIntRaw", 32'(rxIntRaw), 32'd0);
    chk("R1 errStatus", 32'(errStatus), 32'd0);
    chk("R1 canAccept", 32'(canAccept), 32'd1);

    // R12: pop of an empty queue right after reset (slot contents are zero).
    step(0, 0, 8'h00, 3'd0, 1);
    chk("R12 still empty", 32'(rxEmpty), 32'd1);
    chk("R12 errStatus from zero slot", 32'(errStatus), 32'd0);
    errKnown = 1; errM = '0;

    flip(1);

    // Sweep every start offset: fill, overflow, refill, drain (R3, R5, R9).
    for (int off = 0; off < 16; off++) begin
      for (int k = 0; k < off; k++) step(1, 0, 8'(k), 3'd0, 0);
      for (int k = 0; k < off; k++) step(0, 0, 8'h00, 3'd0, 1);
      for (int k = 0; k < 16; k++) step(1, 0, 8'(off * 16 + k), 3'(k), 0);
      step(1, 0, 8'hEE, 3'd0, 0);
      step(0, 0, 8'h00, 3'd0, 1);
      step(1, 0, 8'hAB, 3'd1, 0);
      for (int k = 0; k < 16; k++) step(0, 0, 8'h00, 3'd0, 1, (k == 15) ? "R9" : "R3");
    end

    // R10: push and pop together at several fill levels.
    for (int lvl = 1; lvl < 6; lvl += 2) begin
      for (int k = 0; k < lvl; k++) step(1, 0, 8'(8'h30 + k), 3'd2, 0);
      step(1, 0, 8'h55, 3'd3, 1, "R10");
      chk("R10 count unchanged", 32'(rxEmpty), 32'd0);
      for (int k = 0; k < lvl; k++) step(0, 0, 8'h00, 3'd0, 1, "R10");
    end

    // R8: break together with a character; the break wins.
    step(1, 1, 8'h77, 3'd1, 0);
    step(0, 0, 8'h00, 3'd0, 1, "R8");
    chk("R8 break code in status", 32'(errStatus), 32'h4);

    // Single holding-register mode (R2, R5, R9).
    flip(0);
    step(1, 0, 8'h21, 3'd0, 0);
    chk("R5 single full", 32'(rxFull), 32'd1);
    step(1, 0, 8'h22, 3'd0, 0);
    step(1, 0, 8'h23, 3'd0, 1, "R9");
    step(0, 0, 8'h00, 3'd0, 1);
    step(1, 0, 8'h24, 3'd1, 0);
    step(0, 0, 8'h00, 3'd0, 1, "R9");
    chk("R9 overrun bit seen", 32'(errStatus), 32'h9);

    // Flush a non-empty deep queue; interrupt survives until a pop (R7, R11).
    flip(1);
    for (int k = 0; k < 3; k++) step(1, 0, 8'(8'h40 + k), 3'd0, 0);
    flip(0);
    chk("R7 int still set", 32'(rxIntRaw), 32'd1);
    step(0, 0, 8'h00, 3'd0, 1);
    chk("R7 pop on empty clears int", 32'(rxIntRaw), 32'd0);
    step(1, 0, 8'h5A, 3'd0, 0);
    step(0, 0, 8'h00, 3'd0, 1, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule